// File: doc/BRIEF.md
# Dual-Quad Register Access Mapper

This block sits between a decoded serial-bus transaction port and a register file for eight channels. The register file is stored as two four-channel banks: a low quad for channels 1 to 4 and a high quad for channels 5 to 8. For every byte of a transaction, the block decides which bank is addressed and which command offset that bank sees. It gates the bank write strobes. It also forms the byte returned to the bus master.

The block has two access views and switches between them at run time.

- **Byte view (default).** The two quads answer at two adjacent target addresses. Bit 0 of the target address selects the quad. The command offset advances by one per byte.
- **Word view.** Only the even target address answers. Successive bytes alternate between the low and the high quad. Measurement pairs (30h to 3Fh) follow their own ordering. Configuration bits shared by both quads are merged when read.

The block takes its mode from copies of the general-configuration bits that it captures when writes pass through it.

Top module: `dqm_mapper`

## Requirements
- R1: After reset, `wide_mode`, `multibit_prio` and `rd_valid` are all 0.
- R2: In byte view, a target whose bits [6:1] equal those of `BASE_TGT` reaches the low quad when bit 0 is 0 and the high quad when bit 0 is 1. The bank command is `txn_cmd + txn_idx`.
- R3: Writing a 1 to bit 5 of command 17h in either quad sets `wide_mode` from the next cycle on.
- R4: `wide_mode` returns to 0 only once bit 5 of 17h has been written to 0 in both quads. Clearing it in one quad alone keeps the word view.
- R5: In word view, outside 30h to 3Fh, an even `txn_idx` reaches the low quad and an odd one reaches the high quad. The bank command is `txn_cmd + (txn_idx >> 1)`.
- R6: In word view, a read at an even command from 30h to 3Eh returns bytes in this order: low-quad low byte, low-quad high byte, high-quad low byte, high-quad high byte. Each 16-bit value is held low byte first, at the even offset and the one above it.
- R7: In word view, a 2-byte read at the odd command just above a measurement offset (31h to 3Fh) returns the high-quad value at the even offset, low byte first.
- R8: Reads of pin status (11h) report bit 0 as the quad index in byte view (0 for low, 1 for high). In word view, bit 0 reads 0 for both quads. All other bits come from the bank.
- R9: `multibit_prio` is 1 while bit 4 of 17h was last written as 1 in either quad, and 0 once it has been written as 0 in both.
- R10: In word view, reads of 17h from either quad show bit 5 as 1 and bit 4 as `multibit_prio`. Other bits come from the bank.
- R11: Writes that reach the high quad at 60h, 62h or 63h do not assert `hi_we`. The high-quad content there stays unchanged.
- R12: In word view, a transaction to the odd target asserts no write strobe, and a read returns FFh.
- R13: A transaction whose target bits [6:1] differ from `BASE_TGT` asserts no write strobe, and a read returns FFh.
- R14: A read transaction gives `rd_valid`=1 with its byte in the following cycle. A write gives `rd_valid`=0 in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| txn_valid | input | 1 | One transaction byte is presented this cycle |
| txn_target | input | 7 | Target address of the transaction |
| txn_cmd | input | 8 | Command (register offset) of the transaction |
| txn_write | input | 1 | 1 for a write byte, 0 for a read byte |
| txn_idx | input | 3 | Index of this byte within the transaction |
| txn_wdata | input | 8 | Write data byte |
| lo_cmd | output | 8 | Command offset presented to the low quad |
| lo_we | output | 1 | Write strobe of the low quad |
| lo_wdata | output | 8 | Write data for the low quad |
| lo_rdata | input | 8 | Read data of the low quad at `lo_cmd` |
| hi_cmd | output | 8 | Command offset presented to the high quad |
| hi_we | output | 1 | Write strobe of the high quad |
| hi_wdata | output | 8 | Write data for the high quad |
| hi_rdata | input | 8 | Read data of the high quad at `hi_cmd` |
| rd_valid | output | 1 | Read byte is valid |
| rd_data | output | 8 | Read byte |
| wide_mode | output | 1 | 1 while the word view is active |
| multibit_prio | output | 1 | Effective multi-bit priority selection |

## Verification
The hardest state to reach is the one where the word-view bit is set in only one quad. In that state a clear written to the other quad must leave the word view in place. Clearing the bit in the high quad afterwards then needs a word-view write at the even target with an odd byte index, because the odd target is ignored in that view.

The stimulus builds this history in order:
1. Set the bit through the high quad in byte view.
2. Clear it through the low quad at byte index 0.
3. Clear it through the high quad at byte index 1.
4. Confirm the return to byte view with a high-quad pin-status read.

Along the way, the merged 17h reads and the measurement orderings are checked while both priority and word bits sit in different quads.

// File: rtl/dqm_pkg.sv
package dqm_pkg;
    localparam int BYTE_W = 8;

    localparam logic [BYTE_W-1:0] CMD_GENCFG  = 8'h17;
    localparam logic [BYTE_W-1:0] CMD_PINSTAT = 8'h11;
    localparam logic [BYTE_W-1:0] CMD_MEAS_LO = 8'h30;
    localparam logic [BYTE_W-1:0] CMD_MEAS_HI = 8'h3F;
    localparam logic [BYTE_W-1:0] CMD_SRAM_CTL = 8'h60;
    localparam logic [BYTE_W-1:0] CMD_SRAM_AL  = 8'h62;
    localparam logic [BYTE_W-1:0] CMD_SRAM_AH  = 8'h63;

    localparam int BIT_WIDE = 5;
    localparam int BIT_MBP  = 4;
    localparam int BIT_QIDX = 0;

    localparam logic [BYTE_W-1:0] IGNORED_BYTE = 8'hFF;

    typedef struct packed {
        logic              ignore;
        logic              sel_hi;
        logic [BYTE_W-1:0] cmd;
    } route_t;

    function automatic logic is_meas(input logic [BYTE_W-1:0] c);
        return (c >= CMD_MEAS_LO) && (c <= CMD_MEAS_HI);
    endfunction

    function automatic logic is_low_only(input logic [BYTE_W-1:0] c);
        return (c == CMD_SRAM_CTL) || (c == CMD_SRAM_AL) || (c == CMD_SRAM_AH);
    endfunction
endpackage

// File: rtl/dqm_route.sv
module dqm_route
    import dqm_pkg::*;
#(
    parameter int          TGT_W    = 7,
    parameter int          IDX_W    = 3,
    parameter logic [6:0]  BASE_TGT = 7'h20
) (
    input  logic [TGT_W-1:0]  target,
    input  logic [BYTE_W-1:0] cmd,
    input  logic [IDX_W-1:0]  idx,
    input  logic              wide,
    output route_t            route
);
    localparam int PAIR_SHIFT = 1;
    localparam int MEAS_SHIFT = 2;

    logic              tgt_match;
    logic [BYTE_W-1:0] idx_ext;
    logic [BYTE_W-1:0] idx_half;
    logic [BYTE_W-1:0] meas_step;
    logic [BYTE_W-1:0] meas_base;

    always_comb begin
        tgt_match = (target[TGT_W-1:1] == BASE_TGT[TGT_W-1:1]);
        idx_ext   = BYTE_W'(idx);
        idx_half  = BYTE_W'(idx >> PAIR_SHIFT);
        meas_step = BYTE_W'(idx >> MEAS_SHIFT) << 1;
        meas_base = {cmd[BYTE_W-1:1], 1'b0};

        route.ignore = !tgt_match || (wide && target[0]);
        route.sel_hi = 1'b0;
        route.cmd    = cmd;

        if (!wide) begin
            route.sel_hi = target[0];
            route.cmd    = cmd + idx_ext;
        end else if (is_meas(cmd)) begin
            route.sel_hi = cmd[0] ^ idx[1];
            route.cmd    = meas_base + meas_step + BYTE_W'(idx[0]);
        end else begin
            route.sel_hi = idx[0];
            route.cmd    = cmd + idx_half;
        end
    end
endmodule

// File: rtl/dqm_mode_track.sv
module dqm_mode_track
    import dqm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lo_we,
    input  logic              hi_we,
    input  logic [BYTE_W-1:0] cmd,
    input  logic [BYTE_W-1:0] wdata,
    output logic              wide,
    output logic              mbp
);
    typedef struct packed {
        logic [1:0] wide_bit;
        logic [1:0] mbp_bit;
    } mode_state_t;

    mode_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (cmd == CMD_GENCFG) begin
            if (lo_we) begin
                st_d.wide_bit[0] = wdata[BIT_WIDE];
                st_d.mbp_bit[0]  = wdata[BIT_MBP];
            end
            if (hi_we) begin
                st_d.wide_bit[1] = wdata[BIT_WIDE];
                st_d.mbp_bit[1]  = wdata[BIT_MBP];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign wide = |st_q.wide_bit;
    assign mbp  = |st_q.mbp_bit;

    assert_wide_rise_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wide) |-> $past((lo_we || hi_we) && cmd == CMD_GENCFG && wdata[BIT_WIDE]));

    assert_wide_fall_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(wide) |-> $past((lo_we || hi_we) && cmd == CMD_GENCFG && !wdata[BIT_WIDE]));
endmodule

// File: rtl/dqm_read_merge.sv
module dqm_read_merge
    import dqm_pkg::*;
(
    input  logic              ignore,
    input  logic              sel_hi,
    input  logic [BYTE_W-1:0] cmd,
    input  logic              wide,
    input  logic              mbp,
    input  logic [BYTE_W-1:0] lo_rdata,
    input  logic [BYTE_W-1:0] hi_rdata,
    output logic [BYTE_W-1:0] rbyte
);
    always_comb begin
        rbyte = sel_hi ? hi_rdata : lo_rdata;
        if (cmd == CMD_PINSTAT) begin
            rbyte[BIT_QIDX] = wide ? 1'b0 : sel_hi;
        end
        if (wide && cmd == CMD_GENCFG) begin
            rbyte[BIT_WIDE] = 1'b1;
            rbyte[BIT_MBP]  = mbp;
        end
        if (ignore) begin
            rbyte = IGNORED_BYTE;
        end
    end
endmodule

// File: rtl/dqm_mapper.sv
module dqm_mapper
    import dqm_pkg::*;
#(
    parameter int         TGT_W    = 7,
    parameter int         IDX_W    = 3,
    parameter logic [6:0] BASE_TGT = 7'h20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              txn_valid,
    input  logic [TGT_W-1:0]  txn_target,
    input  logic [7:0]        txn_cmd,
    input  logic              txn_write,
    input  logic [IDX_W-1:0]  txn_idx,
    input  logic [7:0]        txn_wdata,
    output logic [7:0]        lo_cmd,
    output logic              lo_we,
    output logic [7:0]        lo_wdata,
    input  logic [7:0]        lo_rdata,
    output logic [7:0]        hi_cmd,
    output logic              hi_we,
    output logic [7:0]        hi_wdata,
    input  logic [7:0]        hi_rdata,
    output logic              rd_valid,
    output logic [7:0]        rd_data,
    output logic              wide_mode,
    output logic              multibit_prio
);
    typedef struct packed {
        logic              rd_valid;
        logic [BYTE_W-1:0] rd_data;
    } rd_state_t;

    rd_state_t  st_d, st_q;
    route_t     route;
    logic       wr_ok;
    logic [BYTE_W-1:0] merged;

    dqm_route #(
        .TGT_W    (TGT_W),
        .IDX_W    (IDX_W),
        .BASE_TGT (BASE_TGT)
    ) u_route (
        .target (txn_target),
        .cmd    (txn_cmd),
        .idx    (txn_idx),
        .wide   (wide_mode),
        .route  (route)
    );

    always_comb begin
        wr_ok    = txn_valid && txn_write && !route.ignore;
        lo_we    = wr_ok && !route.sel_hi;
        hi_we    = wr_ok && route.sel_hi && !is_low_only(route.cmd);
        lo_cmd   = route.cmd;
        hi_cmd   = route.cmd;
        lo_wdata = txn_wdata;
        hi_wdata = txn_wdata;
    end

    dqm_mode_track u_mode (
        .clk   (clk),
        .rst_n (rst_n),
        .lo_we (lo_we),
        .hi_we (hi_we),
        .cmd   (route.cmd),
        .wdata (txn_wdata),
        .wide  (wide_mode),
        .mbp   (multibit_prio)
    );

    dqm_read_merge u_merge (
        .ignore   (route.ignore),
        .sel_hi   (route.sel_hi),
        .cmd      (route.cmd),
        .wide     (wide_mode),
        .mbp      (multibit_prio),
        .lo_rdata (lo_rdata),
        .hi_rdata (hi_rdata),
        .rbyte    (merged)
    );

    always_comb begin
        st_d          = st_q;
        st_d.rd_valid = txn_valid && !txn_write;
        if (txn_valid && !txn_write) begin
            st_d.rd_data = merged;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rd_valid = st_q.rd_valid;
    assign rd_data  = st_q.rd_data;

    assert_rd_follows_R14: assert property (@(posedge clk) disable iff (!rst_n)
        (txn_valid && !txn_write) |=> rd_valid);

    assert_no_rd_on_write_R14: assert property (@(posedge clk) disable iff (!rst_n)
        (txn_valid && txn_write) |=> !rd_valid);

    assert_sram_hi_blocked_R11: assert property (@(posedge clk) disable iff (!rst_n)
        hi_we |-> !(hi_cmd == CMD_SRAM_CTL || hi_cmd == CMD_SRAM_AL || hi_cmd == CMD_SRAM_AH));

    assert_odd_no_write_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (txn_valid && wide_mode && txn_target[0]) |-> (!lo_we && !hi_we));

    assert_odd_reads_ones_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (txn_valid && !txn_write && wide_mode && txn_target[0]) |=> (rd_data == IGNORED_BYTE));

    assert_foreign_no_write_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (txn_valid && txn_target[TGT_W-1:1] != BASE_TGT[TGT_W-1:1]) |-> (!lo_we && !hi_we));

    assert_pin_a0_wide_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (txn_valid && !txn_write && wide_mode && !route.ignore && lo_cmd == CMD_PINSTAT)
        |=> !rd_data[BIT_QIDX]);
endmodule

// File: tb/dqm_mapper_test.sv
module dqm_mapper_test;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       txn_valid = 1'b0;
    logic [6:0] txn_target = '0;
    logic [7:0] txn_cmd = '0;
    logic       txn_write = 1'b0;
    logic [2:0] txn_idx = '0;
    logic [7:0] txn_wdata = '0;
    logic [7:0] lo_cmd, hi_cmd, lo_wdata, hi_wdata, rd_data;
    logic [7:0] lo_rdata, hi_rdata;
    logic       lo_we, hi_we, rd_valid, wide_mode, multibit_prio;

    logic [7:0] lo_mem [256];
    logic [7:0] hi_mem [256];

    int tests = 0;
    int fails = 0;
    bit done = 0;
    logic cap_lo_we, cap_hi_we;

    always #(CLK_PERIOD/2) clk = ~clk;

    dqm_mapper uut (
        .clk(clk), .rst_n(rst_n), .txn_valid(txn_valid), .txn_target(txn_target),
        .txn_cmd(txn_cmd), .txn_write(txn_write), .txn_idx(txn_idx), .txn_wdata(txn_wdata),
        .lo_cmd(lo_cmd), .lo_we(lo_we), .lo_wdata(lo_wdata), .lo_rdata(lo_rdata),
        .hi_cmd(hi_cmd), .hi_we(hi_we), .hi_wdata(hi_wdata), .hi_rdata(hi_rdata),
        .rd_valid(rd_valid), .rd_data(rd_data), .wide_mode(wide_mode),
        .multibit_prio(multibit_prio)
    );

    assign lo_rdata = lo_mem[lo_cmd];
    assign hi_rdata = hi_mem[hi_cmd];

    always @(posedge clk) begin
        if (lo_we) lo_mem[lo_cmd] <= lo_wdata;
        if (hi_we) hi_mem[hi_cmd] <= hi_wdata;
    end

    // {target, cmd, write, idx, wdata, expected read byte}
    localparam logic [34:0] VEC [NVEC] = '{
        {7'h20, 8'h12, 1'b0, 3'd0, 8'h00, 8'h12},
        {7'h21, 8'h12, 1'b0, 3'd0, 8'h00, 8'hED},
        {7'h20, 8'h12, 1'b0, 3'd2, 8'h00, 8'h14},
        {7'h21, 8'h30, 1'b0, 3'd1, 8'h00, 8'hCE},
        {7'h20, 8'h11, 1'b0, 3'd0, 8'h00, 8'hA4},
        {7'h21, 8'h11, 1'b0, 3'd0, 8'h00, 8'hA5},
        {7'h21, 8'h13, 1'b1, 3'd0, 8'h5A, 8'h00},
        {7'h21, 8'h13, 1'b0, 3'd0, 8'h00, 8'h5A},
        {7'h20, 8'h13, 1'b0, 3'd0, 8'h00, 8'h13},
        {7'h21, 8'h60, 1'b1, 3'd0, 8'h77, 8'h00},
        {7'h21, 8'h60, 1'b0, 3'd0, 8'h00, 8'h9F},
        {7'h20, 8'h60, 1'b1, 3'd0, 8'h66, 8'h00},
        {7'h20, 8'h60, 1'b0, 3'd0, 8'h00, 8'h66},
        {7'h22, 8'h12, 1'b0, 3'd0, 8'h00, 8'hFF},
        {7'h23, 8'h12, 1'b1, 3'd0, 8'h00, 8'h00},
        {7'h21, 8'h12, 1'b0, 3'd0, 8'h00, 8'hED}
    };

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    // One transaction byte; read result is captured one cycle later.
    task automatic txn(input logic [6:0] tg, input logic [7:0] c, input logic w,
                       input logic [2:0] ix, input logic [7:0] wd);
        @(negedge clk);
        txn_valid = 1'b1; txn_target = tg; txn_cmd = c;
        txn_write = w; txn_idx = ix; txn_wdata = wd;
        #1;
        cap_lo_we = lo_we;
        cap_hi_we = hi_we;
        @(negedge clk);
        txn_valid = 1'b0; txn_write = 1'b0;
    endtask

    task automatic rd(input string req, input logic [6:0] tg, input logic [7:0] c,
                      input logic [2:0] ix, input logic [7:0] exp);
        txn(tg, c, 1'b0, ix, 8'h00);
        chk({req, " valid"}, {7'd0, rd_valid}, 8'h01);
        chk(req, rd_data, exp);
    endtask

    initial begin
        for (int i = 0; i < 256; i++) begin
            lo_mem[i] = 8'(i);
            hi_mem[i] = ~8'(i);
        end
        lo_mem[8'h17] = 8'h00; hi_mem[8'h17] = 8'h00;
        lo_mem[8'h11] = 8'hA5; hi_mem[8'h11] = 8'hA5;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 wide", {7'd0, wide_mode}, 8'h00);
        chk("R1 mbp", {7'd0, multibit_prio}, 8'h00);
        chk("R1 rd_valid", {7'd0, rd_valid}, 8'h00);

        for (int v = 0; v < NVEC; v++) begin
            logic [34:0] e;
            e = VEC[v];
            txn(e[34:28], e[27:20], e[19], e[18:16], e[15:8]);
            if (e[19]) begin
                chk("R14 no rd after write", {7'd0, rd_valid}, 8'h00);
            end else begin
                chk("R14 rd_valid", {7'd0, rd_valid}, 8'h01);
                chk("R2/R8/R11/R13 vector read", rd_data, e[7:0]);
            end
        end
        chk("R11 sram hi not written", hi_mem[8'h60], 8'h9F);
        chk("R13 foreign write no lo change", lo_mem[8'h12], 8'h12);

        txn(7'h20, 8'h17, 1'b1, 3'd0, 8'h10);
        chk("R9 mbp set lo", {7'd0, multibit_prio}, 8'h01);
        chk("R3 still byte view", {7'd0, wide_mode}, 8'h00);
        rd("R10 no merge in byte view", 7'h20, 8'h17, 3'd0, 8'h10);

        txn(7'h21, 8'h17, 1'b1, 3'd0, 8'h20);
        chk("R3 wide via hi quad", {7'd0, wide_mode}, 8'h01);

        rd("R10 merged lo", 7'h20, 8'h17, 3'd0, 8'h30);
        rd("R10 merged hi", 7'h20, 8'h17, 3'd1, 8'h30);
        rd("R5 idx0", 7'h20, 8'h12, 3'd0, 8'h12);
        rd("R5 idx1", 7'h20, 8'h12, 3'd1, 8'hED);
        rd("R5 idx2", 7'h20, 8'h12, 3'd2, 8'h13);
        rd("R5 idx3", 7'h20, 8'h12, 3'd3, 8'h5A);
        rd("R6 b0", 7'h20, 8'h30, 3'd0, 8'h30);
        rd("R6 b1", 7'h20, 8'h30, 3'd1, 8'h31);
        rd("R6 b2", 7'h20, 8'h30, 3'd2, 8'hCF);
        rd("R6 b3", 7'h20, 8'h30, 3'd3, 8'hCE);
        rd("R6 last pair b2", 7'h20, 8'h3E, 3'd2, 8'hC1);
        rd("R7 b0", 7'h20, 8'h31, 3'd0, 8'hCF);
        rd("R7 b1", 7'h20, 8'h31, 3'd1, 8'hCE);
        rd("R7 top b1", 7'h20, 8'h3F, 3'd1, 8'hC0);
        rd("R8 wide lo", 7'h20, 8'h11, 3'd0, 8'hA4);
        rd("R8 wide hi", 7'h20, 8'h11, 3'd1, 8'hA4);

        rd("R12 odd read", 7'h21, 8'h12, 3'd0, 8'hFF);
        txn(7'h21, 8'h12, 1'b1, 3'd0, 8'h99);
        chk("R12 odd no strobe", {6'd0, cap_lo_we, cap_hi_we}, 8'h00);
        rd("R12 lo unchanged", 7'h20, 8'h12, 3'd0, 8'h12);

        txn(7'h20, 8'h62, 1'b1, 3'd1, 8'h44);
        chk("R11 hi_we blocked", {7'd0, cap_hi_we}, 8'h00);
        rd("R11 hi 62h unchanged", 7'h20, 8'h62, 3'd1, 8'h9D);

        txn(7'h20, 8'h17, 1'b1, 3'd0, 8'h00);
        chk("R4 one quad clear keeps wide", {7'd0, wide_mode}, 8'h01);
        chk("R9 mbp cleared both", {7'd0, multibit_prio}, 8'h00);
        txn(7'h20, 8'h17, 1'b1, 3'd1, 8'h00);
        chk("R4 both clear exits", {7'd0, wide_mode}, 8'h00);
        rd("R4 byte view A0", 7'h21, 8'h11, 3'd0, 8'hA5);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule